// File: doc/BRIEF.md
# Vectored Interrupt Controller with Paired Vector Slots

This block collects interrupt events from eight external lines, twelve internal event strobes and a software break request. It presents one request line and a 4-bit vector index to the processor. Sixteen vector slots exist. Slot 0 belongs to the software break, which nothing can mask. Slots 1 to 15 are maskable. Five of these slots are each shared by two sources, and a per-pair select bit decides which of the two sources competes for the slot.

Each external line passes through a two-stage synchroniser. An edge detector then reacts to the rising or falling edge, as chosen per line by its polarity bit. External lines 0 and 4 can instead be fed from two alternate pins. A register bus reads and writes the request, enable, edge/pin and pair-select registers. The processor drives its interrupt-disable flag into the block and acknowledges the request. On that acknowledge the block clears the served request and pulses an output that tells the processor to set its disable flag.

Register map, with 2-bit addresses:
- 0 (requests): bits 19:0 hold one pending bit per source.
- 1 (enables): bits 15:1 hold one enable per slot; bit 0 always reads 0.
- 2 (edge/pin): bits 7:0 give each external line's polarity, where 1 means falling and 0 means rising. Bit 8 selects the alternate pins.
- 3 (pair select): bits 4:0, where 1 selects the alternate source.

Source numbering:
- External line i is source i.
- Internal strobe j is source 8+j.
- Slot s (1..15) has source s-1 as its primary source.
- The shared slots are 1, 4, 7, 10 and 13, that is slot 1+3k for k = 0..4. Pair k has source 15+k as its alternate.

Top module: `vec_irq_ctrl`

## Requirements
- R1: An external line sets the request bit of its source on the edge chosen by its polarity bit in register 2 (0 rising, 1 falling). The bit is set within four clock cycles of the pin change. The opposite edge sets nothing.
- R2: A one-cycle pulse on internal strobe j sets request bit 8+j at the next clock edge.
- R3: A write to register 0 clears each request bit whose data bit is 0 and leaves the others unchanged. Writing 1 never sets a request bit.
- R4: A maskable slot is raised only when its selected source's request bit is 1, its enable bit in register 1 is 1, and the disable flag input is 0. The request output is then asserted with the slot number as the vector.
- R5: A software break request raises vector 0 even with the disable flag at 1 and all enables at 0.
- R6: When several slots are eligible, the lowest slot number is presented.
- R7: An acknowledge while the request is high drops the request output at the next edge. It also pulses the disable-set output for exactly one cycle and clears the served source's request bit, while other pending bits remain. The next pending slot is presented two cycles later.
- R8: From assertion until acknowledge, the request output stays high and the vector stays unchanged, even if higher-priority events arrive or the disable flag changes.
- R9: For shared slot 1+3k, bit k of register 3 selects the alternate source 15+k (1) or the primary source 3k (0). The unselected source still latches its request bit but does not raise the slot.
- R10: Bit 8 of register 2 routes alternate pin 0 to external line 0 and alternate pin 1 to external line 4. While it is set, the primary pins of those lines have no effect.
- R11: Edge detection works on the line level XORed with its polarity bit. Changing a line's polarity from 0 to 1 while the line is low therefore sets that line's request bit.
- R12: After reset all registers read 0, and the request output, vector and disable-set output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| ext_pin_i | input | 8 | Primary external interrupt pins |
| ext_alt_pin_i | input | 2 | Alternate pins for external lines 0 and 4 |
| int_evt_i | input | 12 | Internal event strobes |
| brk_i | input | 1 | Software break request strobe |
| iflag_i | input | 1 | Processor interrupt-disable flag |
| ack_i | input | 1 | Acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 4 | Vector slot index |
| mask_set_o | output | 1 | One-cycle pulse: processor must set its disable flag |

## Verification
A wrongly latched or lost request bit shows up at the next read of register 0, and at the request output within two cycles of it becoming eligible. A fault in the slot-to-source mapping or the pair select shows up as a wrong vector or a missing request as soon as that slot competes. A broken handshake state shows up in the cycle after an acknowledge as a request that does not drop, a missing disable-set pulse, a request bit that stays set, or a vector that changes while it is held.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int N_EXT       = 8;
    localparam int N_INTL      = 12;
    localparam int N_SRC       = N_EXT + N_INTL;
    localparam int N_SLOT      = 16;
    localparam int N_PAIR      = 5;
    localparam int PAIR_STRIDE = 3;
    localparam int ALT_BASE    = N_SLOT - 1;
    localparam int N_ALT_PIN   = 2;
    localparam int ALT_LINE_A  = 0;
    localparam int ALT_LINE_B  = 4;
    localparam int SYNC_STAGES = 2;
    localparam int DW          = 32;
    localparam int AW          = 2;
    localparam int SLOT_W      = $clog2(N_SLOT);
    localparam int SRC_W       = $clog2(N_SRC);

    typedef enum logic [AW-1:0] {
        REG_REQ  = 2'd0,
        REG_EN   = 2'd1,
        REG_EDGE = 2'd2,
        REG_SEL  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_HOLD = 2'd1,
        ARB_GAP  = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic              brk;
        logic [SRC_W-1:0]  src;
        logic [SLOT_W-1:0] slot;
    } grant_t;

    // Pair number served by a slot, or -1 when the slot has one source
    function automatic int pair_index(int slot);
        if (slot >= 1 && ((slot - 1) % PAIR_STRIDE) == 0
            && ((slot - 1) / PAIR_STRIDE) < N_PAIR)
            return (slot - 1) / PAIR_STRIDE;
        return -1;
    endfunction

    // Index of the alternate pin feeding an external line, or -1
    function automatic int alt_pin_of(int line);
        if (line == ALT_LINE_A) return 0;
        if (line == ALT_LINE_B) return 1;
        return -1;
    endfunction
endpackage

// File: rtl/vic_edge_det.sv
module vic_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic falling,
    output logic evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl;

    // Polarity-adjusted level: an active edge is always a 0->1 change here
    assign lvl = sync_q[STAGES-1] ^ falling;
    assign evt = lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= lvl;
        end
    end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int NSLOT = N_SLOT,
    parameter int NEXT  = N_EXT,
    parameter int NPAIR = N_PAIR,
    parameter int DWID  = DW,
    parameter int SW    = SRC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DWID-1:0] bus_wdata,
    output logic [DWID-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_evt,
    input  logic            clr_vld,
    input  logic [SW-1:0]   clr_src,
    output logic [NSRC-1:0] req_o,
    output logic [NSLOT-1:0] en_o,
    output logic [NEXT-1:0] falling_o,
    output logic            alt_pins_o,
    output logic [NPAIR-1:0] pair_sel_o
);
    logic [NSRC-1:0]  req_q;
    logic [NSLOT-1:0] en_q;
    logic [NEXT-1:0]  fall_q;
    logic             alt_q;
    logic [NPAIR-1:0] sel_q;
    logic [NSRC-1:0]  keep_mask;
    logic [NSRC-1:0]  ack_mask;
    reg_addr_e        addr;

    assign addr = reg_addr_e'(bus_addr);

    always_comb begin
        keep_mask = '1;
        if (bus_we && addr == REG_REQ)
            keep_mask = bus_wdata[NSRC-1:0];
        ack_mask = '0;
        if (clr_vld)
            ack_mask = NSRC'(1) << clr_src;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            en_q   <= '0;
            fall_q <= '0;
            alt_q  <= 1'b0;
            sel_q  <= '0;
        end else begin
            // new events win over any clear in the same cycle
            req_q <= (req_q & keep_mask & ~ack_mask) | src_evt;
            if (bus_we) begin
                unique case (addr)
                    REG_EN:   en_q <= bus_wdata[NSLOT-1:0] & ~NSLOT'(1);
                    REG_EDGE: begin
                        fall_q <= bus_wdata[NEXT-1:0];
                        alt_q  <= bus_wdata[NEXT];
                    end
                    REG_SEL:  sel_q <= bus_wdata[NPAIR-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            REG_REQ:  bus_rdata[NSRC-1:0] = req_q;
            REG_EN:   bus_rdata[NSLOT-1:0] = en_q;
            REG_EDGE: begin
                bus_rdata[NEXT-1:0] = fall_q;
                bus_rdata[NEXT]     = alt_q;
            end
            REG_SEL:  bus_rdata[NPAIR-1:0] = sel_q;
            default:  ;
        endcase
    end

    assign req_o      = req_q;
    assign en_o       = en_q;
    assign falling_o  = fall_q;
    assign alt_pins_o = alt_q;
    assign pair_sel_o = sel_q;
endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int NSLOT = N_SLOT,
    parameter int NPAIR = N_PAIR,
    parameter int ABASE = ALT_BASE
) (
    input  logic [NSRC-1:0]  req,
    input  logic [NSLOT-1:0] en,
    input  logic [NPAIR-1:0] pair_sel,
    input  logic             brk_pend,
    input  logic             iflag,
    output logic             any,
    output grant_t           win
);
    logic [SRC_W-1:0] slot_src [NSLOT];
    logic [NSLOT-1:0] elig;

    assign slot_src[0] = '0;
    assign elig[0]     = brk_pend;

    for (genvar s = 1; s < NSLOT; s++) begin : g_slot
        localparam int K = pair_index(s);
        if (K >= 0) begin : g_shared
            assign slot_src[s] = pair_sel[K] ? SRC_W'(ABASE + K) : SRC_W'(s - 1);
        end else begin : g_single
            assign slot_src[s] = SRC_W'(s - 1);
        end
        assign elig[s] = req[slot_src[s]] & en[s] & ~iflag;
    end

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (!any && elig[s]) begin
                any      = 1'b1;
                win.slot = SLOT_W'(s);
                win.src  = slot_src[s];
                win.brk  = (s == 0);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [N_EXT-1:0]     ext_pin_i,
    input  logic [N_ALT_PIN-1:0] ext_alt_pin_i,
    input  logic [N_INTL-1:0]    int_evt_i,
    input  logic                 brk_i,
    input  logic                 iflag_i,
    input  logic                 ack_i,
    output logic                 irq_o,
    output logic [SLOT_W-1:0]    vec_o,
    output logic                 mask_set_o
);
    logic [N_EXT-1:0]  line_pin;
    logic [N_EXT-1:0]  ext_evt;
    logic [N_SRC-1:0]  src_evt;
    logic [N_SRC-1:0]  req_w;
    logic [N_SLOT-1:0] en_w;
    logic [N_EXT-1:0]  falling_w;
    logic              alt_pins_w;
    logic [N_PAIR-1:0] pair_sel_w;
    logic              any_w;
    grant_t            win_w;

    arb_state_e state_q;
    grant_t     grant_q;
    logic       irq_q;
    logic       mask_q;
    logic       brk_q;
    logic       acked;
    logic       clr_vld;

    for (genvar i = 0; i < N_EXT; i++) begin : g_line
        localparam int AP = alt_pin_of(i);
        if (AP >= 0) begin : g_alt
            assign line_pin[i] = alt_pins_w ? ext_alt_pin_i[AP] : ext_pin_i[i];
        end else begin : g_pri
            assign line_pin[i] = ext_pin_i[i];
        end
        vic_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst     (rst),
            .pin     (line_pin[i]),
            .falling (falling_w[i]),
            .evt     (ext_evt[i])
        );
    end

    assign src_evt = {int_evt_i, ext_evt};

    assign acked   = (state_q == ARB_HOLD) && ack_i;
    assign clr_vld = acked && !grant_q.brk;

    vic_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .src_evt    (src_evt),
        .clr_vld    (clr_vld),
        .clr_src    (grant_q.src),
        .req_o      (req_w),
        .en_o       (en_w),
        .falling_o  (falling_w),
        .alt_pins_o (alt_pins_w),
        .pair_sel_o (pair_sel_w)
    );

    vic_arb u_arb (
        .req      (req_w),
        .en       (en_w),
        .pair_sel (pair_sel_w),
        .brk_pend (brk_q),
        .iflag    (iflag_i),
        .any      (any_w),
        .win      (win_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
            irq_q   <= 1'b0;
            mask_q  <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            mask_q <= 1'b0;
            if (brk_i)
                brk_q <= 1'b1;
            else if (acked && grant_q.brk)
                brk_q <= 1'b0;
            unique case (state_q)
                ARB_IDLE: if (any_w) begin
                    grant_q <= win_w;
                    irq_q   <= 1'b1;
                    state_q <= ARB_HOLD;
                end
                ARB_HOLD: if (ack_i) begin
                    irq_q   <= 1'b0;
                    mask_q  <= 1'b1;
                    state_q <= ARB_GAP;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign irq_o      = irq_q;
    assign vec_o      = grant_q.slot;
    assign mask_set_o = mask_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic [SLOT_W-1:0] vec_o,
    input logic              ack_i,
    input logic              iflag_i,
    input logic              mask_set_o,
    input logic [N_SRC-1:0]  req_w,
    input logic [N_SRC-1:0]  src_evt
);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_i) |=> (!irq_o && mask_set_o));

    // R7
    mask_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mask_set_o |=> !mask_set_o);

    // R3
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_w & ~$past(req_w) & ~$past(src_evt)) == '0));

    // R4
    masked_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && vec_o != '0) |-> !$past(iflag_i));
endmodule

bind vec_irq_ctrl vic_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_o      (irq_o),
    .vec_o      (vec_o),
    .ack_i      (ack_i),
    .iflag_i    (iflag_i),
    .mask_set_o (mask_set_o),
    .req_w      (req_w),
    .src_evt    (src_evt)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  ext_pin_i;
    logic [1:0]  ext_alt_pin_i;
    logic [11:0] int_evt_i;
    logic        brk_i, iflag_i, ack_i;
    logic        irq_o, mask_set_o;
    logic [3:0]  vec_o;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin_i(ext_pin_i),
        .ext_alt_pin_i(ext_alt_pin_i), .int_evt_i(int_evt_i), .brk_i(brk_i),
        .iflag_i(iflag_i), .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o),
        .mask_set_o(mask_set_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic pulse_int(input int j);
        int_evt_i[j] = 1'b1;
        cyc(1);
        int_evt_i[j] = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        cyc(1);
        ack_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        ext_pin_i = '0; ext_alt_pin_i = '0; int_evt_i = '0;
        brk_i = 1'b0; iflag_i = 1'b1; ack_i = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R12 irq", {31'd0, irq_o}, 32'd0);
        chk("R12 vec", {28'd0, vec_o}, 32'd0);
        chk("R12 mask_set", {31'd0, mask_set_o}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R12 register", d, 32'd0);
        end
    endtask

    task automatic t_edges();
        logic [31:0] d;
        do_reset();
        ext_pin_i[2] = 1'b1;               // rising edge, polarity 0
        cyc(4); rd(2'd0, d);
        chk("R1 rising sets", d, 32'h4);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h4);                   // line 2 falling; pin high: no event
        cyc(4); rd(2'd0, d);
        chk("R1 no spurious when high", d, 32'h0);
        ext_pin_i[2] = 1'b0;
        cyc(4); rd(2'd0, d);
        chk("R1 falling sets", d, 32'h4);
        wr(2'd0, 32'h0);
        ext_pin_i[2] = 1'b1;               // rising edge in falling mode
        cyc(4); rd(2'd0, d);
        chk("R1 opposite edge ignored", d, 32'h0);
        // R11: polarity change on a low line
        wr(2'd2, 32'h24);                  // line 5 now falling, pin 5 low
        cyc(4); rd(2'd0, d);
        chk("R11 polarity change latches", d, 32'h20);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h4);                   // back to rising while low
        cyc(4); rd(2'd0, d);
        chk("R11 reverse change no event", d, 32'h0);
    endtask

    task automatic t_internal_and_write();
        logic [31:0] d;
        do_reset();
        pulse_int(3);
        rd(2'd0, d);
        chk("R2 strobe sets next edge", d, 32'h800);
        pulse_int(4);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d);
        chk("R3 write ones keeps", d, 32'h1800);
        wr(2'd0, ~32'h800);
        rd(2'd0, d);
        chk("R3 write zero clears one", d, 32'h1000);
        wr(2'd0, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d);
        chk("R3 ones cannot set", d, 32'h0);
        wr(2'd1, 32'hFFFF);
        rd(2'd1, d);
        chk("R3 enable bit0 reads 0", d, 32'hFFFE);
    endtask

    task automatic t_mask();
        do_reset();
        wr(2'd1, 32'h1000);                // enable slot 12
        pulse_int(3);                      // source 11 -> slot 12
        cyc(4);
        chk("R4 masked by flag", {31'd0, irq_o}, 32'd0);
        iflag_i = 1'b0;
        cyc(3);
        chk("R4 raised irq", {31'd0, irq_o}, 32'd1);
        chk("R4 raised vec", {28'd0, vec_o}, 32'd12);
        do_reset();
        iflag_i = 1'b0;
        pulse_int(3);
        cyc(4);
        chk("R4 masked by enable", {31'd0, irq_o}, 32'd0);
        wr(2'd1, 32'h1000);
        cyc(3);
        chk("R4 enable raises", {27'd0, irq_o, vec_o}, 32'h1C);
    endtask

    task automatic t_break();
        do_reset();
        brk_i = 1'b1; cyc(1); brk_i = 1'b0;
        cyc(3);
        chk("R5 break unmaskable", {27'd0, irq_o, vec_o}, 32'h10);
        do_ack();
        chk("R5 break ack drops", {30'd0, irq_o, mask_set_o}, 32'h1);
        cyc(4);
        chk("R5 break served once", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        do_reset();
        wr(2'd1, 32'hFFFE);
        int_evt_i[3] = 1'b1; int_evt_i[1] = 1'b1;   // slots 12 and 10
        cyc(1);
        int_evt_i = '0;
        iflag_i = 1'b0;
        cyc(3);
        chk("R6 lowest slot wins", {27'd0, irq_o, vec_o}, 32'h1A);
        pulse_int(0);                      // slot 9 arrives while held
        iflag_i = 1'b1;
        cyc(3);
        chk("R8 vector held", {27'd0, irq_o, vec_o}, 32'h1A);
        iflag_i = 1'b0;
        do_ack();
        chk("R7 ack drops irq", {30'd0, irq_o, mask_set_o}, 32'h1);
        rd(2'd0, d);
        chk("R7 served bit cleared", d, 32'h900);
        cyc(1);
        chk("R7 pulse one cycle", {31'd0, mask_set_o}, 32'd0);
        cyc(1);
        chk("R7 next slot presented", {27'd0, irq_o, vec_o}, 32'h19);
        do_ack();
        cyc(2);
        chk("R6 remaining slot", {27'd0, irq_o, vec_o}, 32'h1C);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        do_reset();
        iflag_i = 1'b0;
        wr(2'd1, 32'h2);                   // slot 1
        pulse_int(7);                      // source 15, alternate of pair 0
        cyc(4);
        chk("R9 unselected no irq", {31'd0, irq_o}, 32'd0);
        rd(2'd0, d);
        chk("R9 unselected still latches", d, 32'h8000);
        wr(2'd3, 32'h1);
        cyc(2);
        chk("R9 alternate selected", {27'd0, irq_o, vec_o}, 32'h11);
        do_ack();
        rd(2'd0, d);
        chk("R9 alternate bit cleared", d, 32'h0);
    endtask

    task automatic t_altpin();
        logic [31:0] d;
        do_reset();
        wr(2'd2, 32'h100);                 // alternate pins
        ext_pin_i[4] = 1'b1;
        cyc(5); rd(2'd0, d);
        chk("R10 primary pin ignored", d, 32'h0);
        ext_pin_i[4] = 1'b0;
        cyc(5);
        ext_alt_pin_i[1] = 1'b1;
        cyc(5); rd(2'd0, d);
        chk("R10 alternate pin line 4", d, 32'h10);
        ext_alt_pin_i[0] = 1'b1;
        cyc(5); rd(2'd0, d);
        chk("R10 alternate pin line 0", d, 32'h11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_edges();
        t_internal_and_write();
        t_mask();
        t_break();
        t_priority();
        t_shared();
        t_altpin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule